// File: doc/BRIEF.md
# Operand-Capturing Issue Queue

This block is a small out-of-order issue queue for integer operations, sitting between an in-order dispatch stage and one execution unit. Operands are read at dispatch time: each incoming instruction brings an opcode, the rename tag its result will be written under, and two source fields. A source field carries the operand value when the producer has already finished, and otherwise carries the rename tag of the producing instruction.

Waiting entries watch a single result broadcast bus. When a finishing instruction puts its tag and result on the bus, every entry compares its pending source tags against the broadcast tag and copies the result into each matching field. An entry whose two sources are both present is ready. The oldest ready entry goes to the execution unit, one per cycle. A full indication tells the dispatch stage to hold back, and a flush input discards all entries.

Top module: `wakeup_issue_queue`

## Requirements
- R1: After reset, `iss_valid_o` and `full_o` are 0.
- R2: An instruction dispatched with both `*_rdy_i` set is presented on the issue outputs in the cycle right after the dispatch edge, if no older entry is ready.
- R3: When a source `*_rdy_i` is 0, the low `TAG_W` bits of that source field are a tag. The entry is not issued until a broadcast carries that tag. The broadcast data then replaces the field and is issued as the operand.
- R4: A broadcast whose tag matches no pending source leaves every waiting entry pending, and nothing is issued because of it.
- R5: A broadcast in the same cycle as the dispatch of an instruction that waits on that tag is captured by the new entry.
- R6: One broadcast wakes every pending source that matches the tag, across all entries and in both source slots.
- R7: When several entries are ready, exactly one is issued per cycle, and it is the one dispatched earliest.
- R8: `full_o` is 1 exactly when all `DEPTH` entries are occupied. A dispatch while `full_o` is 1 is dropped and never issues.
- R9: `flush_i` empties every entry at the next edge and takes priority over a dispatch in the same cycle. The flushed instructions never issue, even on later broadcasts.
- R10: The issue packet carries the entry's opcode, its destination tag, source A on `iss_a_o` and source B on `iss_b_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard all entries |
| disp_valid_i | input | 1 | Dispatch request |
| disp_opc_i | input | OPC_W | Opcode of the dispatched instruction |
| disp_dst_i | input | TAG_W | Destination rename tag |
| disp_a_i | input | DATA_W | Source A value, or source tag in the low bits |
| disp_a_rdy_i | input | 1 | 1: `disp_a_i` is a value; 0: it is a tag |
| disp_b_i | input | DATA_W | Source B value, or source tag in the low bits |
| disp_b_rdy_i | input | 1 | 1: `disp_b_i` is a value; 0: it is a tag |
| full_o | output | 1 | No free entry; dispatch must wait |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Tag of the finishing instruction |
| bc_data_i | input | DATA_W | Result of the finishing instruction |
| iss_valid_o | output | 1 | Issue packet valid |
| iss_opc_o | output | OPC_W | Issued opcode |
| iss_dst_o | output | TAG_W | Issued destination tag |
| iss_a_o | output | DATA_W | Issued source A value |
| iss_b_o | output | DATA_W | Issued source B value |

## Verification
A broadcast can arrive in the same cycle as the dispatch of an instruction that consumes it. It can also arrive in the same cycle as an issue or a flush. The bench drives these coincidences on purpose: a dispatch that waits on the very tag being broadcast, a broadcast during a flush, and a long pseudo-random run where dispatch, broadcast and issue overlap freely. Each cycle a bench-side age-ordered model predicts which instruction should leave and with which operand values. The design's issue outputs are compared with that prediction.

// File: rtl/wiq_pkg.sv
package wiq_pkg;
   localparam int NUM_SRC = 2;
   typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_sel_e;
endpackage

// File: rtl/wiq_slot.sv
module wiq_slot
   import wiq_pkg::*;
#(
   parameter int OPC_W  = 4,
   parameter int TAG_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             flush_i,
   input  logic                             load_i,
   input  logic [OPC_W-1:0]                 ld_opc_i,
   input  logic [TAG_W-1:0]                 ld_dst_i,
   input  logic [NUM_SRC-1:0][DATA_W-1:0]   ld_opnd_i,
   input  logic [NUM_SRC-1:0]               ld_rdy_i,
   input  logic                             bc_valid_i,
   input  logic [TAG_W-1:0]                 bc_tag_i,
   input  logic [DATA_W-1:0]                bc_data_i,
   input  logic                             issue_i,
   output logic                             busy_o,
   output logic                             ready_o,
   output logic [OPC_W-1:0]                 opc_o,
   output logic [TAG_W-1:0]                 dst_o,
   output logic [NUM_SRC-1:0][DATA_W-1:0]   opnd_o
);
   logic                           busy_q;
   logic [NUM_SRC-1:0]             have_q;
   logic [OPC_W-1:0]               opc_q;
   logic [TAG_W-1:0]               dst_q;
   logic [NUM_SRC-1:0][DATA_W-1:0] opnd_q;
   logic [NUM_SRC-1:0]             hit_ld;
   logic [NUM_SRC-1:0]             hit_wait;

   always_comb begin
      for (int s = 0; s < NUM_SRC; s++) begin
         hit_ld[s]   = bc_valid_i && !ld_rdy_i[s] &&
                       (ld_opnd_i[s][TAG_W-1:0] == bc_tag_i);
         hit_wait[s] = bc_valid_i && busy_q && !have_q[s] &&
                       (opnd_q[s][TAG_W-1:0] == bc_tag_i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         have_q <= '0;
         opc_q  <= '0;
         dst_q  <= '0;
         opnd_q <= '0;
      end else if (flush_i) begin
         busy_q <= 1'b0;
         have_q <= '0;
      end else if (load_i) begin
         busy_q <= 1'b1;
         opc_q  <= ld_opc_i;
         dst_q  <= ld_dst_i;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (hit_ld[s]) begin
               opnd_q[s] <= bc_data_i;
               have_q[s] <= 1'b1;
            end else begin
               opnd_q[s] <= ld_opnd_i[s];
               have_q[s] <= ld_rdy_i[s];
            end
         end
      end else begin
         if (issue_i) begin
            busy_q <= 1'b0;
         end
         for (int s = 0; s < NUM_SRC; s++) begin
            if (hit_wait[s]) begin
               opnd_q[s] <= bc_data_i;
               have_q[s] <= 1'b1;
            end
         end
      end
   end

   assign busy_o  = busy_q;
   assign ready_o = busy_q && (&have_q);
   assign opc_o   = opc_q;
   assign dst_o   = dst_q;
   assign opnd_o  = opnd_q;

   // R7: the picker may only grant a slot whose operands are both present
   p_grant_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |-> (busy_q && (&have_q)));

   // R10: a grant must never coincide with loading the same slot
   p_no_load_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_i && load_i));

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_chk
      // R3: a matching broadcast is written into a waiting field
      p_wake_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_wait[s] && !flush_i && !load_i) |=>
            (have_q[s] && opnd_q[s] == $past(bc_data_i)));
      // R5: same-cycle broadcast is taken by the incoming entry
      p_load_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (load_i && hit_ld[s] && !flush_i) |=>
            (have_q[s] && opnd_q[s] == $past(bc_data_i)));
   end
endmodule

// File: rtl/wiq_free_pick.sv
module wiq_free_pick #(
   parameter int DEPTH = 4
) (
   input  logic [DEPTH-1:0] busy_i,
   output logic [DEPTH-1:0] free_oh_o,
   output logic             full_o
);
   always_comb begin
      free_oh_o = '0;
      for (int i = DEPTH-1; i >= 0; i--) begin
         if (!busy_i[i]) begin
            free_oh_o = '0;
            free_oh_o[i] = 1'b1;
         end
      end
   end

   assign full_o = &busy_i;
endmodule

// File: rtl/wiq_age_pick.sv
module wiq_age_pick #(
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] alloc_i,
   input  logic [DEPTH-1:0] busy_i,
   input  logic [DEPTH-1:0] rdy_i,
   output logic [DEPTH-1:0] grant_o
);
   // older_q[j][i] set: entry j was dispatched before entry i
   logic [DEPTH-1:0][DEPTH-1:0] older_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         older_q <= '0;
      end else begin
         for (int k = 0; k < DEPTH; k++) begin
            if (alloc_i[k]) begin
               for (int j = 0; j < DEPTH; j++) begin
                  older_q[k][j] <= 1'b0;
                  if (j != k) begin
                     older_q[j][k] <= busy_i[j];
                  end
               end
            end
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_pick
      logic blocked;
      always_comb begin
         blocked = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (j != i && rdy_i[j] && older_q[j][i]) begin
               blocked = 1'b1;
            end
         end
      end
      assign grant_o[i] = rdy_i[i] && !blocked;
   end

   // R7: at most one entry leaves per cycle
   p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   // R7: some ready entry is always chosen
   p_grant_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|rdy_i) |-> (|grant_o));
   // R8: allocation targets one entry at a time
   p_alloc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_i));
endmodule

// File: rtl/wakeup_issue_queue.sv
module wakeup_issue_queue
   import wiq_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int OPC_W  = 4,
   parameter int TAG_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              disp_valid_i,
   input  logic [OPC_W-1:0]  disp_opc_i,
   input  logic [TAG_W-1:0]  disp_dst_i,
   input  logic [DATA_W-1:0] disp_a_i,
   input  logic              disp_a_rdy_i,
   input  logic [DATA_W-1:0] disp_b_i,
   input  logic              disp_b_rdy_i,
   output logic              full_o,
   input  logic              bc_valid_i,
   input  logic [TAG_W-1:0]  bc_tag_i,
   input  logic [DATA_W-1:0] bc_data_i,
   output logic              iss_valid_o,
   output logic [OPC_W-1:0]  iss_opc_o,
   output logic [TAG_W-1:0]  iss_dst_o,
   output logic [DATA_W-1:0] iss_a_o,
   output logic [DATA_W-1:0] iss_b_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("wakeup_issue_queue: DEPTH must be at least 2");
   end
   if (TAG_W > DATA_W) begin : g_bad_tag
      $error("wakeup_issue_queue: a tag must fit in an operand field");
   end
   if (OPC_W < 1) begin : g_bad_opc
      $error("wakeup_issue_queue: OPC_W must be positive");
   end

   logic [DEPTH-1:0]               busy;
   logic [DEPTH-1:0]               rdy;
   logic [DEPTH-1:0]               grant;
   logic [DEPTH-1:0]               free_oh;
   logic [DEPTH-1:0]               alloc;
   logic                           accept;
   logic [NUM_SRC-1:0][DATA_W-1:0] ld_opnd;
   logic [NUM_SRC-1:0]             ld_rdy;
   logic [OPC_W-1:0]               s_opc  [DEPTH];
   logic [TAG_W-1:0]               s_dst  [DEPTH];
   logic [NUM_SRC-1:0][DATA_W-1:0] s_opnd [DEPTH];

   assign ld_opnd[SRC_A] = disp_a_i;
   assign ld_opnd[SRC_B] = disp_b_i;
   assign ld_rdy[SRC_A]  = disp_a_rdy_i;
   assign ld_rdy[SRC_B]  = disp_b_rdy_i;

   wiq_free_pick #(.DEPTH(DEPTH)) u_free (
      .busy_i    (busy),
      .free_oh_o (free_oh),
      .full_o    (full_o)
   );

   assign accept = disp_valid_i && !full_o && !flush_i;
   assign alloc  = accept ? free_oh : '0;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      wiq_slot #(.OPC_W(OPC_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .flush_i    (flush_i),
         .load_i     (alloc[i]),
         .ld_opc_i   (disp_opc_i),
         .ld_dst_i   (disp_dst_i),
         .ld_opnd_i  (ld_opnd),
         .ld_rdy_i   (ld_rdy),
         .bc_valid_i (bc_valid_i),
         .bc_tag_i   (bc_tag_i),
         .bc_data_i  (bc_data_i),
         .issue_i    (grant[i]),
         .busy_o     (busy[i]),
         .ready_o    (rdy[i]),
         .opc_o      (s_opc[i]),
         .dst_o      (s_dst[i]),
         .opnd_o     (s_opnd[i])
      );
   end

   wiq_age_pick #(.DEPTH(DEPTH)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (alloc),
      .busy_i  (busy),
      .rdy_i   (rdy),
      .grant_o (grant)
   );

   always_comb begin
      iss_opc_o = '0;
      iss_dst_o = '0;
      iss_a_o   = '0;
      iss_b_o   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (grant[i]) begin
            iss_opc_o = iss_opc_o | s_opc[i];
            iss_dst_o = iss_dst_o | s_dst[i];
            iss_a_o   = iss_a_o   | s_opnd[i][SRC_A];
            iss_b_o   = iss_b_o   | s_opnd[i][SRC_B];
         end
      end
   end
   assign iss_valid_o = |grant;

   // R9: a flush leaves nothing to issue and frees every entry
   p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (!iss_valid_o && !full_o));
   // R8: the chosen free entry is really free
   p_alloc_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc & busy) == '0);
   // R8: a full queue that issues nothing stays full
   p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !iss_valid_o && !flush_i) |=> full_o);
   // R2: a fully-ready dispatch into an empty queue issues next cycle
   p_ready_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && disp_a_rdy_i && disp_b_rdy_i && busy == '0) |=> iss_valid_o);
endmodule

// File: tb/wakeup_issue_queue_bench.sv
module wakeup_issue_queue_bench;
   localparam int DEPTH = 4, OPC_W = 4, TAG_W = 3, DATA_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush_i = 1'b0;
   logic disp_valid_i = 1'b0;
   logic [OPC_W-1:0]  disp_opc_i = '0;
   logic [TAG_W-1:0]  disp_dst_i = '0;
   logic [DATA_W-1:0] disp_a_i = '0, disp_b_i = '0;
   logic disp_a_rdy_i = 1'b0, disp_b_rdy_i = 1'b0;
   logic bc_valid_i = 1'b0;
   logic [TAG_W-1:0]  bc_tag_i = '0;
   logic [DATA_W-1:0] bc_data_i = '0;
   logic full_o, iss_valid_o;
   logic [OPC_W-1:0]  iss_opc_o;
   logic [TAG_W-1:0]  iss_dst_o;
   logic [DATA_W-1:0] iss_a_o, iss_b_o;

   always #2.5 clk = ~clk;

   wakeup_issue_queue #(.DEPTH(DEPTH), .OPC_W(OPC_W), .TAG_W(TAG_W), .DATA_W(DATA_W))
   u_wakeup_issue_queue (.*);

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference model: entries with dispatch sequence numbers
   bit              m_busy [DEPTH];
   int              m_seq  [DEPTH];
   logic [OPC_W-1:0]  m_opc [DEPTH];
   logic [TAG_W-1:0]  m_dst [DEPTH];
   logic [DATA_W-1:0] m_a [DEPTH], m_b [DEPTH];
   bit              m_ha [DEPTH], m_hb [DEPTH];
   int              seq_ctr = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_disp(input int opc, input int dst, input bit ar, input int a,
                           input bit br, input int b);
      disp_valid_i = 1'b1; disp_opc_i = OPC_W'(opc); disp_dst_i = TAG_W'(dst);
      disp_a_rdy_i = ar; disp_a_i = DATA_W'(a);
      disp_b_rdy_i = br; disp_b_i = DATA_W'(b);
   endtask

   task automatic set_bc(input int tag, input int data);
      bc_valid_i = 1'b1; bc_tag_i = TAG_W'(tag); bc_data_i = DATA_W'(data);
   endtask

   // compare outputs with model, advance model and clock, clear one-shot inputs
   task automatic cycle(input string req);
      int pick = -1;
      int nbusy = 0;
      int fr = -1;
      bit tmatch;
      for (int i = 0; i < DEPTH; i++) begin
         if (m_busy[i]) nbusy++;
         if (m_busy[i] && m_ha[i] && m_hb[i] && (pick < 0 || m_seq[i] < m_seq[pick])) pick = i;
      end
      chk(req, "full", int'(full_o), int'(nbusy == DEPTH));
      chk(req, "iss_valid", int'(iss_valid_o), int'(pick >= 0));
      if (pick >= 0 && iss_valid_o) begin
         chk("R10", "iss_opc", int'(iss_opc_o), int'(m_opc[pick]));
         chk("R10", "iss_dst", int'(iss_dst_o), int'(m_dst[pick]));
         chk(req, "iss_a", int'(iss_a_o), int'(m_a[pick]));
         chk(req, "iss_b", int'(iss_b_o), int'(m_b[pick]));
      end
      if (flush_i) begin
         for (int i = 0; i < DEPTH; i++) m_busy[i] = 0;
      end else begin
         if (pick >= 0) m_busy[pick] = 0;
         for (int i = 0; i < DEPTH; i++) begin
            if (m_busy[i] && bc_valid_i) begin
               if (!m_ha[i] && m_a[i][TAG_W-1:0] == bc_tag_i) begin m_a[i] = bc_data_i; m_ha[i] = 1; end
               if (!m_hb[i] && m_b[i][TAG_W-1:0] == bc_tag_i) begin m_b[i] = bc_data_i; m_hb[i] = 1; end
            end
         end
         if (disp_valid_i && nbusy < DEPTH) begin
            for (int i = DEPTH-1; i >= 0; i--) if (!m_busy[i] && !(pick == i)) fr = i;
            if (fr < 0) fr = pick;
            m_busy[fr] = 1; m_seq[fr] = seq_ctr++; m_opc[fr] = disp_opc_i; m_dst[fr] = disp_dst_i;
            m_a[fr] = disp_a_i; m_ha[fr] = disp_a_rdy_i;
            m_b[fr] = disp_b_i; m_hb[fr] = disp_b_rdy_i;
            tmatch = bc_valid_i && !disp_a_rdy_i && disp_a_i[TAG_W-1:0] == bc_tag_i;
            if (tmatch) begin m_a[fr] = bc_data_i; m_ha[fr] = 1; end
            tmatch = bc_valid_i && !disp_b_rdy_i && disp_b_i[TAG_W-1:0] == bc_tag_i;
            if (tmatch) begin m_b[fr] = bc_data_i; m_hb[fr] = 1; end
         end
      end
      @(posedge clk);
      @(negedge clk);
      disp_valid_i = 1'b0; bc_valid_i = 1'b0; flush_i = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin m_busy[i] = 0; m_ha[i] = 0; m_hb[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty after reset
      cycle("R1");
      // R2: both sources ready, issues next cycle
      set_disp(3, 1, 1, 8'h21, 1, 8'h42); cycle("R2");
      cycle("R2"); cycle("R2");
      // R3: source B waits on tag 5
      set_disp(4, 2, 1, 8'h11, 0, 5); cycle("R3");
      cycle("R3"); cycle("R3");
      set_bc(5, 8'h99); cycle("R3");
      cycle("R3"); cycle("R3");
      // R4: non-matching tag leaves the entry waiting
      set_disp(5, 3, 0, 2, 1, 8'h07); cycle("R4");
      set_bc(3, 8'hAA); cycle("R4");
      cycle("R4");
      set_bc(2, 8'h5C); cycle("R4");
      cycle("R4"); cycle("R4");
      // R5: broadcast in the dispatch cycle is captured
      set_disp(6, 4, 0, 4, 0, 4); set_bc(4, 8'h3E); cycle("R5");
      cycle("R5"); cycle("R5");
      // R6: one broadcast wakes sources in several entries
      set_disp(7, 5, 0, 6, 1, 8'h01); cycle("R6");
      set_disp(8, 6, 0, 6, 0, 6); cycle("R6");
      set_bc(6, 8'hC3); cycle("R6");
      cycle("R6"); cycle("R6"); cycle("R6");
      // R7: age order differs from slot order
      set_disp(1, 0, 0, 7, 1, 8'h10); cycle("R7");
      set_disp(2, 1, 0, 2, 1, 8'h20); cycle("R7");
      set_disp(3, 2, 1, 8'h30, 0, 2); cycle("R7");
      set_bc(7, 8'h77); cycle("R7");
      set_disp(4, 3, 0, 2, 0, 2); cycle("R7");
      set_bc(2, 8'hE2); cycle("R7");
      repeat (4) cycle("R7");
      // R8: fill, then a dropped dispatch
      for (int k = 0; k < DEPTH; k++) begin set_disp(k, k, 0, 3, 1, k); cycle("R8"); end
      set_disp(15, 7, 1, 8'hFF, 1, 8'hFF); cycle("R8");
      cycle("R8");
      set_bc(3, 8'h4D); cycle("R8");
      repeat (DEPTH + 1) cycle("R8");
      // R9: flush beats dispatch, later broadcast wakes nothing
      set_disp(9, 1, 0, 1, 1, 0); cycle("R9");
      set_disp(9, 2, 0, 1, 0, 1); cycle("R9");
      set_disp(10, 3, 1, 1, 1, 1); flush_i = 1'b1; cycle("R9");
      set_bc(1, 8'h61); cycle("R9");
      cycle("R9"); cycle("R9");
      // R10: overlapping dispatch, broadcast, issue and rare flush
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 2) != 0)
            set_disp($urandom_range(0, 15), $urandom_range(0, 7),
                     $urandom_range(0, 1), $urandom_range(0, 255),
                     $urandom_range(0, 1), $urandom_range(0, 255));
         if ($urandom_range(0, 1) != 0) set_bc($urandom_range(0, 7), $urandom_range(0, 255));
         if ($urandom_range(0, 149) == 0) flush_i = 1'b1;
         cycle("R10");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule